// File: doc/BRIEF.md
# Gigabit Ethernet PCS frame sequencer

The sequencer produces the byte stream that an 8b/10b physical coding sublayer encodes for a 1000BASE-X link. It emits an 8-bit code group with a K-character flag on every clock. It wraps one fixed-length frame at a time in ordered sets: a start-of-packet code, then preamble and start-of-frame delimiter, then the header, the payload and the four FCS bytes, then the terminate and carrier-extend codes. Between frames it fills the line with IDLE2 pairs. The frame is assembled from three sources. A 90-byte header vector is captured into a shift register once per frame. Payload bytes are read from an external byte FIFO whose read data arrives two cycles after the request. The FCS comes from an external four-byte CRC port.

A frame starts only when the FIFO holds a whole payload, at least twelve gap bytes have gone out, and the last gap byte sent was the second half of an idle pair. When the payload length is odd, an extra carrier-extend code is added so that every gap begins on an even byte boundary. The block also gives one-cycle pulses that tell the encoder when to correct running disparity and when a frame has been sent, and it keeps a count of sent frames. The payload length `PAY_LEN` is a parameter with a minimum of 10.

Top module: `gbe_frame_seq`

## Requirements
- R1: While `rst_ni` is low, the outputs are: `data_o` = 0x50 with `k_o` = 0, `fifo_rd_o`, `disp_fix_o` and `pkt_sent_o` low, and `pkt_cnt_o` zero. Reset leaves the block in the gap state with its gap-byte count cleared.
- R2: A frame opens with 0xFB with `k_o`=1, then six 0x55 and one 0xD5, all with `k_o`=0, on consecutive cycles.
- R3: The gap is an alternating sequence of 0xBC (`k_o`=1) and 0x50 (`k_o`=0). It starts with 0xBC and lasts at least 12 bytes.
- R4: A frame starts only when all of these hold: `fifo_level_i` ≥ `PAY_LEN`, at least 12 gap bytes have been sent, and the last gap byte was 0x50. With enough data waiting, the next start-of-packet follows exactly 12 gap bytes after the previous frame. Without enough data, the gap continues indefinitely.
- R5: The 90 header bytes follow 0xD5 with `k_o`=0. Header byte 0 is `hdr_i[719:712]` and is sent first. `hdr_i` is captured one cycle before the first header byte is presented; later changes do not affect the frame in flight.
- R6: `fifo_rd_o` is high for exactly `PAY_LEN` consecutive cycles per frame, starting three cycles before the first payload byte is on `data_o`. Payload bytes go out in FIFO order with `k_o`=0, and each is the `fifo_data_i` value present two cycles after its request.
- R7: On the cycle right after the last payload byte, the four FCS bytes start, with no gap: `fcs_i[31:24]` first, then down to `fcs_i[7:0]`, all with `k_o`=0.
- R8: After the FCS come 0xFD and then 0xF7, both with `k_o`=1. An odd `PAY_LEN` adds one more 0xF7, so that the distance from start-of-packet to the first gap byte is always even.
- R9: `disp_fix_o` is high for exactly one cycle per frame: the cycle in which the last 0xF7 of the frame is on `data_o`.
- R10: `pkt_sent_o` is high for one cycle, coinciding with the first 0xF7 of the frame. `pkt_cnt_o` increases by one in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Transmit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hdr_i | input | 720 | Header bytes, byte 0 in the top eight bits |
| fifo_level_i | input | LVL_W | Bytes currently held in the payload FIFO |
| fifo_rd_o | output | 1 | Payload FIFO read request |
| fifo_data_i | input | 8 | FIFO read data, two cycles after request |
| fcs_i | input | 32 | Frame check sequence, most significant byte sent first |
| data_o | output | 8 | Code group byte toward the PCS |
| k_o | output | 1 | High when `data_o` is a K-character |
| disp_fix_o | output | 1 | Disparity-correction pulse at gap entry |
| pkt_sent_o | output | 1 | One-cycle pulse when a frame is complete |
| pkt_cnt_o | output | CNT_W | Number of frames sent |

## Verification
The bench runs an odd payload length and an even payload length side by side, so that the added carrier-extend code and the placement of the disparity pulse are each seen with and without realignment. The FIFO fill level is stepped from empty, to one byte short of a payload, to three payloads. This separates the data condition of the start rule from the gap-count and pair-phase conditions. It also shows back-to-back frames separated by exactly twelve gap bytes, followed by an endless gap once the data runs out. The header vector is changed in the middle of the first frame: the first frame must still carry the old bytes and the next frame must carry the new ones.

// File: rtl/gbe_frame_seq_pkg.sv
package gbe_frame_seq_pkg;

  typedef enum logic [2:0] {
    ST_IPG, ST_PRE, ST_HDR, ST_PAY, ST_FIN, ST_FCS, ST_EPD, ST_RAL
  } seq_st_e;

  typedef struct packed {
    logic       k;
    logic [7:0] d;
  } sym_t;

  localparam int HDR_BYTES = 14 + 20 + 8 + 48;
  localparam int PRE_LEN   = 8;
  localparam int FCS_LEN   = 4;
  localparam int GAP_MIN   = 12;

  localparam logic [7:0] SYM_SOP  = 8'hFB;
  localparam logic [7:0] SYM_PRE  = 8'h55;
  localparam logic [7:0] SYM_SFD  = 8'hD5;
  localparam logic [7:0] SYM_IK   = 8'hBC;
  localparam logic [7:0] SYM_ID   = 8'h50;
  localparam logic [7:0] SYM_TERM = 8'hFD;
  localparam logic [7:0] SYM_EXT  = 8'hF7;

endpackage

// File: rtl/fsq_gap_gen.sv
module fsq_gap_gen
  import gbe_frame_seq_pkg::*;
#(
  parameter int MIN_BYTES = GAP_MIN
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic adv_i,
  output sym_t sym_o,
  output logic pair_ok_o
);
  localparam int CW = $clog2(MIN_BYTES + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(MIN_BYTES);

  logic [CW-1:0] cnt_q;
  logic          phase_q;   // 1: next byte is the data half of the pair

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (!active_i) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (adv_i) begin
      phase_q <= ~phase_q;
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sym_o     = phase_q ? sym_t'{k: 1'b0, d: SYM_ID} : sym_t'{k: 1'b1, d: SYM_IK};
  assign pair_ok_o = (cnt_q == CNT_MAX) && !phase_q;

  AST_GAP_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX); // R3
  AST_GAP_LEAVE_ON_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !adv_i) |-> pair_ok_o); // R4
  AST_GAP_CLEARED_OUTSIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> (cnt_q == '0)); // R3

endmodule

// File: rtl/fsq_hdr_shift.sv
module fsq_hdr_shift #(
  parameter int BYTES = 90
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               shift_i,
  input  logic [BYTES*8-1:0] hdr_i,
  output logic [7:0]         byte_o
);
  localparam int W = BYTES * 8;

  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= hdr_i;
    else if (shift_i) sr_q <= {sr_q[W-9:0], 8'h00};
  end

  assign byte_o = sr_q[W-1 -: 8];

  AST_HDR_LOAD_XOR_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && shift_i)); // R5
  AST_HDR_LOAD_BEFORE_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> shift_i); // R5

endmodule

// File: rtl/fsq_ctrl.sv
module fsq_ctrl
  import gbe_frame_seq_pkg::*;
#(
  parameter int PAY_LEN = 10,
  parameter int HB      = HDR_BYTES,
  parameter int IDX_W   = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output seq_st_e          st_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             hdr_load_o,
  output logic             hdr_shift_o,
  output logic             fifo_rd_o,
  output logic             disp_fix_o,
  output logic             pkt_sent_o
);
  localparam logic [IDX_W-1:0] LAST_PRE = IDX_W'(PRE_LEN - 1);
  localparam logic [IDX_W-1:0] LAST_HDR = IDX_W'(HB - 1);
  localparam logic [IDX_W-1:0] LAST_PAY = IDX_W'(PAY_LEN - 1);
  localparam logic [IDX_W-1:0] LAST_FCS = IDX_W'(FCS_LEN - 1);
  localparam logic [IDX_W-1:0] RD_ON    = IDX_W'(HB - 2);
  localparam logic [IDX_W-1:0] RD_OFF   = IDX_W'(PAY_LEN - 2);
  localparam bit               PAY_ODD  = (PAY_LEN % 2) == 1;

  seq_st_e          st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             disp_q, sent_q;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q + 1'b1;
    unique case (st_q)
      ST_IPG: begin
        idx_d = '0;
        if (start_i) begin
          st_d  = ST_PRE;
          idx_d = IDX_W'(1);  // start cycle already emits the SOP
        end
      end
      ST_PRE: if (idx_q == LAST_PRE) begin st_d = ST_HDR; idx_d = '0; end
      ST_HDR: if (idx_q == LAST_HDR) begin st_d = ST_PAY; idx_d = '0; end
      ST_PAY: if (idx_q == LAST_PAY) begin st_d = ST_FIN; idx_d = '0; end
      ST_FIN: begin st_d = ST_FCS; idx_d = '0; end
      ST_FCS: if (idx_q == LAST_FCS) begin st_d = ST_EPD; idx_d = '0; end
      ST_EPD: begin st_d = PAY_ODD ? ST_RAL : ST_IPG; idx_d = '0; end
      ST_RAL: begin st_d = ST_IPG; idx_d = '0; end
      default: begin st_d = ST_IPG; idx_d = '0; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IPG;
      idx_q  <= '0;
      disp_q <= 1'b0;
      sent_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      disp_q <= (st_d == ST_IPG) && (st_q != ST_IPG);
      sent_q <= (st_q == ST_EPD);
    end
  end

  assign st_o        = st_q;
  assign idx_o       = idx_q;
  assign hdr_load_o  = (st_q == ST_PRE) && (idx_q == LAST_PRE);
  assign hdr_shift_o = (st_q == ST_HDR);
  // issued two cycles ahead of use to cover the memory latency
  assign fifo_rd_o   = ((st_q == ST_HDR) && (idx_q >= RD_ON)) ||
                       ((st_q == ST_PAY) && (idx_q <  RD_OFF));
  assign disp_fix_o  = disp_q;
  assign pkt_sent_o  = sent_q;

  AST_RD_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rd_o |-> (st_q == ST_HDR || st_q == ST_PAY)); // R6
  AST_SENT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_sent_o |=> !pkt_sent_o); // R10
  AST_DISP_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_fix_o |=> !disp_fix_o); // R9
  AST_DISP_AFTER_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_fix_o |-> ($past(st_q) == ST_EPD || $past(st_q) == ST_RAL)); // R9
  AST_FIN_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FIN) |=> (st_q == ST_FCS)); // R7

endmodule

// File: rtl/gbe_frame_seq.sv
module gbe_frame_seq
  import gbe_frame_seq_pkg::*;
#(
  parameter int PAY_LEN = 10,
  parameter int LVL_W   = 16,
  parameter int CNT_W   = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [HDR_BYTES*8-1:0] hdr_i,
  input  logic [LVL_W-1:0]       fifo_level_i,
  output logic                   fifo_rd_o,
  input  logic [7:0]             fifo_data_i,
  input  logic [31:0]            fcs_i,
  output logic [7:0]             data_o,
  output logic                   k_o,
  output logic                   disp_fix_o,
  output logic                   pkt_sent_o,
  output logic [CNT_W-1:0]       pkt_cnt_o
);
  localparam int IDX_MAX = (PAY_LEN > HDR_BYTES) ? PAY_LEN : HDR_BYTES;
  localparam int IDX_W   = $clog2(IDX_MAX + 1);
  localparam logic [IDX_W-1:0] LAST_PRE = IDX_W'(PRE_LEN - 1);
  localparam logic [IDX_W-1:0] LAST_FCS = IDX_W'(FCS_LEN - 1);

  seq_st_e          st;
  logic [IDX_W-1:0] idx;
  logic             hdr_load, hdr_shift, pair_ok, start, gap_adv;
  logic [7:0]       hdr_byte, fcs_byte;
  sym_t             gap_sym, out_q;
  logic [CNT_W-1:0] cnt_q;

  assign start   = (st == ST_IPG) && pair_ok && (fifo_level_i >= LVL_W'(PAY_LEN));
  assign gap_adv = (st == ST_IPG) && !start;

  fsq_ctrl #(.PAY_LEN(PAY_LEN), .HB(HDR_BYTES), .IDX_W(IDX_W)) u_ctrl (
    .clk_i, .rst_ni,
    .start_i    (start),
    .st_o       (st),
    .idx_o      (idx),
    .hdr_load_o (hdr_load),
    .hdr_shift_o(hdr_shift),
    .fifo_rd_o  (fifo_rd_o),
    .disp_fix_o (disp_fix_o),
    .pkt_sent_o (pkt_sent_o)
  );

  fsq_gap_gen #(.MIN_BYTES(GAP_MIN)) u_gap (
    .clk_i, .rst_ni,
    .active_i (st == ST_IPG),
    .adv_i    (gap_adv),
    .sym_o    (gap_sym),
    .pair_ok_o(pair_ok)
  );

  fsq_hdr_shift #(.BYTES(HDR_BYTES)) u_hdr (
    .clk_i, .rst_ni,
    .load_i (hdr_load),
    .shift_i(hdr_shift),
    .hdr_i  (hdr_i),
    .byte_o (hdr_byte)
  );

  // intermediate output register; FCS bytes bypass it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= sym_t'{k: 1'b0, d: SYM_ID};
    end else begin
      unique case (st)
        ST_IPG: out_q <= start ? sym_t'{k: 1'b1, d: SYM_SOP} : gap_sym;
        ST_PRE: out_q <= sym_t'{k: 1'b0, d: (idx == LAST_PRE) ? SYM_SFD : SYM_PRE};
        ST_HDR: out_q <= sym_t'{k: 1'b0, d: hdr_byte};
        ST_PAY: out_q <= sym_t'{k: 1'b0, d: fifo_data_i};
        ST_FIN: out_q <= out_q;
        ST_FCS: if (idx == LAST_FCS) out_q <= sym_t'{k: 1'b1, d: SYM_TERM};
        ST_EPD, ST_RAL: out_q <= sym_t'{k: 1'b1, d: SYM_EXT};
        default: out_q <= out_q;
      endcase
    end
  end

  always_comb begin
    unique case (idx[1:0])
      2'd0:    fcs_byte = fcs_i[31:24];
      2'd1:    fcs_byte = fcs_i[23:16];
      2'd2:    fcs_byte = fcs_i[15:8];
      default: fcs_byte = fcs_i[7:0];
    endcase
  end

  assign data_o = (st == ST_FCS) ? fcs_byte : out_q.d;
  assign k_o    = (st == ST_FCS) ? 1'b0     : out_q.k;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (st == ST_EPD)  cnt_q <= cnt_q + 1'b1;
  end
  assign pkt_cnt_o = cnt_q;

  AST_SOP_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_PRE && $past(st) == ST_IPG) |-> (k_o && data_o == SYM_SOP)); // R2
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_sent_o |-> (pkt_cnt_o == $past(pkt_cnt_o) + CNT_W'(1))); // R10
  AST_SENT_ON_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_sent_o |-> (k_o && data_o == SYM_EXT)); // R10
  AST_DISP_ON_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_fix_o |-> (k_o && data_o == SYM_EXT)); // R9
  AST_NO_READ_EMPTY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_PRE && $past(st) == ST_IPG) |-> ($past(fifo_level_i) >= LVL_W'(PAY_LEN))); // R4

endmodule

// File: tb/sim_gbe_frame_seq.sv
module sim_gbe_lane #(
  parameter int P = 10
) (
  input  logic clk,
  input  logic rst_n,
  output int   n_chk,
  output int   n_fail,
  output logic done
);
  import gbe_frame_seq_pkg::*;
  localparam int LOGN = 700;
  localparam int ODD  = P % 2;
  localparam logic [31:0] FCS = 32'hA1B2C3D4;
  // expected opening sequence {k,data}
  localparam logic [8:0] PRE_TBL [8] = '{9'h1FB, 9'h055, 9'h055, 9'h055,
                                        9'h055, 9'h055, 9'h055, 9'h0D5};

  logic [719:0] hdr, h1, h2;
  logic [15:0]  level;
  logic         rd, k, disp, sent;
  logic [7:0]   dout, d1, d2;
  logic [15:0]  cnt;
  int           wp, rp, n, w3;
  logic         cap_en;

  logic [7:0]  ld   [LOGN];
  logic        lk   [LOGN];
  logic        lrd  [LOGN];
  logic        ldsp [LOGN];
  logic        lsnt [LOGN];
  logic [15:0] lcnt [LOGN];

  function automatic logic [7:0] pay(int i);
    return 8'((i * 37 + 5) & 255);
  endfunction
  function automatic logic [7:0] hb(int seed, int i);
    return 8'((i * 13 + seed * 29 + 1) & 255);
  endfunction
  function automatic logic [7:0] hsel(logic [719:0] h, int i);
    return h[719 - 8*i -: 8];
  endfunction

  assign level = 16'(wp - rp);

  gbe_frame_seq #(.PAY_LEN(P), .LVL_W(16), .CNT_W(16)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .hdr_i(hdr), .fifo_level_i(level),
    .fifo_rd_o(rd), .fifo_data_i(d2), .fcs_i(FCS), .data_o(dout), .k_o(k),
    .disp_fix_o(disp), .pkt_sent_o(sent), .pkt_cnt_o(cnt)
  );

  // FIFO model, two-cycle read latency
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp <= 0; d1 <= 8'h00; d2 <= 8'h00;
    end else begin
      d2 <= d1;
      if (rd) begin
        d1 <= pay(rp);
        rp <= rp + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (cap_en && n < LOGN) begin
      ld[n] = dout; lk[n] = k; lrd[n] = rd; ldsp[n] = disp;
      lsnt[n] = sent; lcnt[n] = cnt;
      n = n + 1;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s P=%0d %s: actual %0h expected %0h", req, P, what, act, exp);
    end
  endtask

  task automatic check_frame(int s, int fno, logic [719:0] h, int off, output int g);
    int e, errs, bad;
    for (int i = 0; i < 8; i++)
      check({lk[s+i], ld[s+i]} == PRE_TBL[i], "R2", "preamble code", {lk[s+i], ld[s+i]}, PRE_TBL[i]);
    errs = 0; bad = -1;
    for (int i = 0; i < 90; i++)
      if (ld[s+8+i] != hsel(h, i) || lk[s+8+i]) begin errs++; if (bad < 0) bad = i; end
    check(errs == 0, "R5", "header mismatches (first index)", bad, -1);
    errs = 0;
    for (int j = 0; j < P; j++) if (!lrd[s+95+j]) errs++;
    check(errs == 0 && !lrd[s+94] && !lrd[s+95+P], "R6", "read window misses", errs, 0);
    errs = 0; bad = -1;
    for (int j = 0; j < P; j++)
      if (ld[s+98+j] != pay(off+j) || lk[s+98+j]) begin errs++; if (bad < 0) bad = j; end
    check(errs == 0, "R6", "payload mismatches (first index)", bad, -1);
    for (int b = 0; b < 4; b++)
      check(ld[s+98+P+b] == FCS[31-8*b -: 8] && !lk[s+98+P+b], "R7", "fcs byte",
            {lk[s+98+P+b], ld[s+98+P+b]}, {1'b0, FCS[31-8*b -: 8]});
    e = s + 102 + P;
    check(lk[e] && ld[e] == 8'hFD, "R8", "terminate", {lk[e], ld[e]}, 9'h1FD);
    check(lk[e+1] && ld[e+1] == 8'hF7, "R8", "extend", {lk[e+1], ld[e+1]}, 9'h1F7);
    if (ODD == 1)
      check(lk[e+2] && ld[e+2] == 8'hF7, "R8", "realign extend", {lk[e+2], ld[e+2]}, 9'h1F7);
    check(lsnt[e+1] && !lsnt[e] && !lsnt[e+2], "R10", "sent pulse", {lsnt[e], lsnt[e+1], lsnt[e+2]}, 3'b010);
    check(lcnt[e+1] == 16'(fno) && lcnt[e] == 16'(fno-1), "R10", "counter", lcnt[e+1], fno);
    check(ldsp[e+1+ODD] && !ldsp[e+ODD] && !ldsp[e+2+ODD], "R9", "disparity pulse",
          {ldsp[e+ODD], ldsp[e+1+ODD], ldsp[e+2+ODD]}, 3'b010);
    g = e + 2 + ODD;
    check(((g - s) % 2) == 0, "R8", "frame length parity", g - s, 0);
    errs = 0;
    for (int i = 0; i < 12; i++)
      if ({lk[g+i], ld[g+i]} != ((i % 2 == 0) ? 9'h1BC : 9'h050)) errs++;
    check(errs == 0, "R3", "gap pattern errors", errs, 0);
  endtask

  initial begin
    int s1, s2, s3, g, nfb, nsnt, ndsp;
    n_chk = 0; n_fail = 0; done = 0; cap_en = 0; n = 0; wp = 0; w3 = 0;
    for (int i = 0; i < 90; i++) begin
      h1[719-8*i -: 8] = hb(1, i);
      h2[719-8*i -: 8] = hb(2, i);
    end
    hdr = h1;
    @(negedge clk);
    check(dout == 8'h50 && !k, "R1", "reset symbol", {k, dout}, 9'h050);
    check(!rd && !disp && !sent && cnt == 16'd0, "R1", "reset controls",
          {rd, disp, sent, cnt}, 0);
    wait (rst_n);
    @(negedge clk);
    cap_en = 1;
    repeat (20) @(negedge clk);
    wp = P - 1;
    repeat (40) @(negedge clk);
    wp = 3 * P;
    #1 w3 = n - 1;
    do @(negedge clk); while (!(dout == 8'hFB && k));
    repeat (10) @(negedge clk);
    hdr = h2;
    wait (n >= LOGN);

    s1 = -1;
    for (int i = 0; i < LOGN; i++) if (s1 < 0 && ld[i] == 8'hFB && lk[i]) s1 = i;
    check(s1 == w3 + 1 || s1 == w3 + 2, "R4", "first start vs data arrival", s1, w3 + 1);
    if (s1 > 0 && s1 + 3 * (130 + P) < LOGN) begin
      check_frame(s1, 1, h1, 0, g);
      s2 = g + 12;
      check(ld[s2] == 8'hFB && lk[s2], "R4", "second start after 12 gap bytes", {lk[s2], ld[s2]}, 9'h1FB);
      check_frame(s2, 2, h2, P, g);
      s3 = g + 12;
      check(ld[s3] == 8'hFB && lk[s3], "R4", "third start after 12 gap bytes", {lk[s3], ld[s3]}, 9'h1FB);
      check_frame(s3, 3, h2, 2 * P, g);
      nfb = 0;
      for (int i = g; i < LOGN; i++) if (ld[i] == 8'hFB && lk[i]) nfb++;
      check(nfb == 0, "R4", "start without data", nfb, 0);
    end
    nsnt = 0; ndsp = 0; nfb = 0;
    for (int i = 0; i < LOGN; i++) begin
      nsnt += int'(lsnt[i]); ndsp += int'(ldsp[i]);
      if (i <= w3 && ld[i] == 8'hFB && lk[i]) nfb++;
    end
    check(nfb == 0, "R4", "start before level reached payload", nfb, 0);
    check(nsnt == 3, "R10", "sent pulses", nsnt, 3);
    check(ndsp == 3, "R9", "disparity pulses", ndsp, 3);
    done = 1;
  end
endmodule

module sim_gbe_frame_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   c0, f0, c1, f1;
  logic d0, d1;
  bit   wd;

  always #4 clk = ~clk;  // 125 MHz

  sim_gbe_lane #(.P(11)) u_odd  (.clk(clk), .rst_n(rst_n), .n_chk(c0), .n_fail(f0), .done(d0));
  sim_gbe_lane #(.P(10)) u_even (.clk(clk), .rst_n(rst_n), .n_chk(c1), .n_fail(f1), .done(d1));

  initial begin
    int tot, bad;
    wd = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    fork
      wait (d0 && d1);
      begin repeat (20000) @(posedge clk); wd = 1; end
    join_any
    disable fork;
    tot = c0 + c1;
    bad = f0 + f1;
    if (wd) begin
      tot++; bad++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("%0d/%0d checks passed", tot - bad, tot);
    $finish;
  end
endmodule